// File: doc/BRIEF.md
# DRAM Refresh Interval Timer with CAS-before-RAS Sequencer

This block keeps external DRAM alive. An 8-bit interval counter advances on ticks from a shared prescaler. When it reaches a programmed compare value, it returns to zero and raises a refresh request. A small sequencer takes that request and drives the RAS and CAS strobes through one CAS-before-RAS refresh cycle. While standby is asserted, the sequencer instead holds the DRAM in self-refresh.

Software programs the block through a plain write port and can read every register, including the live counter, through a combinational read port. The controls are:
- a refresh enable,
- a 3-bit clock-source code,
- the compare value,
- a 3-bit field that marks which areas are DRAM,
- a hold bit. The hold bit decides whether other external bus accesses may continue while a refresh is in progress.

No port of this block carries a data stream, so there is no valid/ready handshake. Writes land on the clock edge where `wr_en` is high and are never stalled.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After an active-low asynchronous reset:
  - `ras_n` and `cas_n` are 1, `refresh_pending` and `seq_busy` are 0, and `ext_allow` is 1.
  - The control register and area field read 0, the compare register reads 0xFF, and the counter reads 0.
- R2: Register addresses are:
  - 0: control. Bit 0 is the refresh enable, bits 3:1 are the clock-source code, bit 4 is the hold bit, and bits 7:5 read 0.
  - 1: compare value.
  - 2: area field in bits 2:0, upper bits read 0.
  - 3: interval counter.

  A write with `wr_en`=1 takes effect at that clock edge. `rd_data` shows the register at `rd_addr` in the same cycle.
- R3: A 12-bit prescaler counts every clock from 0 after reset. Clock-source code k (1 to 7) selects a division of 2, 8, 32, 128, 512, 2048 or 4096, which is 2^n with n = 1, 3, 5, 7, 9, 11 or 12. The counter ticks at each edge where the low n bits of the prescaler are all ones. Code 0 freezes the counter.
- R4: On a tick, the counter goes to 0 if it equals the compare value and otherwise increments. A write to address 3 wins over a tick in the same cycle.
- R5: Refresh is "on" only when the enable is 1 and the area field is nonzero.
  - A tick that finds counter == compare while refresh is on sets `refresh_pending`.
  - The flag stays set until the sequencer accepts it: sequencer idle, refresh on, standby low. It then clears at the same edge where the sequence starts.
  - A match while the flag is already set, or at the accepting edge, adds no further request.
- R6: A CBR refresh shows these states, one clock each unless noted:
  - `cas_n`=0 with `ras_n`=1.
  - Both strobes 0 for 2 clocks.
  - `ras_n`=1 with `cas_n`=0.
  - Both strobes 1 for one precharge clock.

  `seq_busy` is 1 through all five clocks and 0 when the sequencer is idle. Both strobes are 1 whenever the sequencer is idle.
- R7: With the hold bit 0, `ext_allow` stays 1. With the hold bit 1, `ext_allow` is 0 in exactly the five clocks of a CBR refresh.
- R8: Self-refresh starts when standby is high, the sequencer is idle and refresh is on. Standby takes priority over a pending request.
  - `cas_n` goes low for one clock, then both strobes stay low while standby stays high.
  - After standby falls, `ras_n` goes high one clock before `cas_n`, followed by one precharge clock.
  - `ext_allow` is not lowered during self-refresh.
- R9: While refresh is off, no request is raised and neither a CBR refresh nor self-refresh starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| standby | input | 1 | Standby request; enters self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ext_allow | output | 1 | Other external accesses permitted |
| refresh_pending | output | 1 | Refresh request waiting for the sequencer |
| seq_busy | output | 1 | Sequencer not idle |

## Verification
The hardest situation to reach is a compare match that lands while a request is already pending, or at the very edge where the sequencer accepts one. It also matters when standby arrives with a request still waiting. The stimulus reaches these by setting the compare value to 0 on the fastest clock source, so every other clock is a match while five-clock refreshes run back to back. Standby is then raised in the middle of that traffic. A behavioural model that tracks the prescaler phase from reset compares strobes, flags and the rotating register readback on every clock, so any double-counted or lost request shows at once.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 3;
  localparam int AREA_W = 3;
  localparam int PRE_W  = 12;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_AREA = 2'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CLEAD, SQ_ACT, SQ_RREL, SQ_PRE,
    SQ_SLEAD, SQ_SHOLD, SQ_SREL, SQ_SPRE
  } seq_state_t;

  // prescaler bits that must be all ones for a given clock-source code
  function automatic int tap_bits(input int code);
    case (code)
      1: return 1;
      2: return 3;
      3: return 5;
      4: return 7;
      5: return 9;
      6: return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/refresh_regs.sv
module refresh_regs #(
  parameter int DATA_W = refresh_pkg::DATA_W,
  parameter int ADDR_W = refresh_pkg::ADDR_W,
  parameter int SEL_W  = refresh_pkg::SEL_W,
  parameter int AREA_W = refresh_pkg::AREA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              hold_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic [AREA_W-1:0] area_q,
  output logic              cnt_wr
);
  localparam int HOLD_BIT = SEL_W + 1;

  assign cnt_wr = wr_en && (wr_addr == refresh_pkg::A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      hold_q <= 1'b0;
      cmp_q  <= '1;
      area_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        refresh_pkg::A_CTRL: begin
          en_q   <= wr_data[0];
          sel_q  <= wr_data[SEL_W:1];
          hold_q <= wr_data[HOLD_BIT];
        end
        refresh_pkg::A_CMP:  cmp_q  <= wr_data;
        refresh_pkg::A_AREA: area_q <= wr_data[AREA_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/refresh_prescaler.sv
module refresh_prescaler #(
  parameter int PRE_W = refresh_pkg::PRE_W,
  parameter int SEL_W = refresh_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSRC = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pcnt;
  logic [NSRC:0]    tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;
  end

  assign tap[0] = 1'b0;  // code 0: no source, counter frozen
  for (genvar g = 1; g <= NSRC; g++) begin : g_tap
    localparam int K = refresh_pkg::tap_bits(g);
    assign tap[g] = &pcnt[K-1:0];
  end

  assign tick = tap[sel];
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = refresh_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             refresh_on,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q
);
  logic hit;

  assign hit = tick && !cnt_wr && (cnt_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= cnt_wdata;
    end else if (tick) begin
      cnt_q <= (cnt_q == cmp) ? '0 : cnt_q + 1'b1;
    end
  end

  // single pending flag: acceptance clears it and absorbs a same-edge match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (ack)               pend_q <= 1'b0;
    else if (hit && refresh_on) pend_q <= 1'b1;
  end
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer #(
  parameter int ACTIVE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_on,
  input  logic standby,
  input  logic pend,
  output logic ack,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic cbr_busy
);
  import refresh_pkg::*;

  localparam int AW = $clog2(ACTIVE_CYC + 1);

  seq_state_t    st_q, st_d;
  logic [AW-1:0] act_q, act_d;
  logic          start_sr;

  assign start_sr = (st_q == SQ_IDLE) && refresh_on && standby;
  assign ack      = (st_q == SQ_IDLE) && refresh_on && !standby && pend;

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    case (st_q)
      SQ_IDLE: begin
        if (start_sr) st_d = SQ_SLEAD;
        else if (ack) st_d = SQ_CLEAD;
      end
      SQ_CLEAD: begin
        st_d  = SQ_ACT;
        act_d = '0;
      end
      SQ_ACT: begin
        if (act_q == AW'(ACTIVE_CYC - 1)) st_d = SQ_RREL;
        else act_d = act_q + 1'b1;
      end
      SQ_RREL:  st_d = SQ_PRE;
      SQ_PRE:   st_d = SQ_IDLE;
      SQ_SLEAD: st_d = SQ_SHOLD;
      SQ_SHOLD: if (!standby) st_d = SQ_SREL;
      SQ_SREL:  st_d = SQ_SPRE;
      SQ_SPRE:  st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      act_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    ras_n = !((st_q == SQ_ACT) || (st_q == SQ_SHOLD));
    cas_n = !((st_q == SQ_CLEAD) || (st_q == SQ_ACT) || (st_q == SQ_RREL) ||
              (st_q == SQ_SLEAD) || (st_q == SQ_SHOLD) || (st_q == SQ_SREL));
    busy     = (st_q != SQ_IDLE);
    cbr_busy = (st_q == SQ_CLEAD) || (st_q == SQ_ACT) ||
               (st_q == SQ_RREL)  || (st_q == SQ_PRE);
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int DATA_W     = refresh_pkg::DATA_W,
  parameter int ADDR_W     = refresh_pkg::ADDR_W,
  parameter int SEL_W      = refresh_pkg::SEL_W,
  parameter int AREA_W     = refresh_pkg::AREA_W,
  parameter int PRE_W      = refresh_pkg::PRE_W,
  parameter int ACTIVE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              standby,
  output logic              ras_n,
  output logic              cas_n,
  output logic              ext_allow,
  output logic              refresh_pending,
  output logic              seq_busy
);
  localparam int CTRL_PAD = DATA_W - SEL_W - 2;
  localparam int AREA_PAD = DATA_W - AREA_W;

  logic              en_q, hold_q, cnt_wr, tick, refresh_on, ack, cbr_busy;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] cmp_q, cnt_q;
  logic [AREA_W-1:0] area_q;

  refresh_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .AREA_W(AREA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .sel_q(sel_q), .hold_q(hold_q), .cmp_q(cmp_q), .area_q(area_q),
    .cnt_wr(cnt_wr)
  );

  assign refresh_on = en_q && (area_q != '0);

  refresh_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
  );

  refresh_interval_timer #(.CNT_W(DATA_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .refresh_on(refresh_on), .cmp(cmp_q),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data), .ack(ack), .cnt_q(cnt_q),
    .pend_q(refresh_pending)
  );

  cbr_sequencer #(.ACTIVE_CYC(ACTIVE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .refresh_on(refresh_on), .standby(standby),
    .pend(refresh_pending), .ack(ack), .ras_n(ras_n), .cas_n(cas_n),
    .busy(seq_busy), .cbr_busy(cbr_busy)
  );

  assign ext_allow = !(hold_q && cbr_busy);

  always_comb begin
    case (rd_addr)
      refresh_pkg::A_CTRL: rd_data = {{CTRL_PAD{1'b0}}, hold_q, sel_q, en_q};
      refresh_pkg::A_CMP:  rd_data = cmp_q;
      refresh_pkg::A_AREA: rd_data = {{AREA_PAD{1'b0}}, area_q};
      default:             rd_data = cnt_q;
    endcase
  end
endmodule

// File: rtl/refresh_checker.sv
module refresh_checker #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              ext_allow,
  input logic              refresh_pending,
  input logic              seq_busy,
  input logic              hold_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              cnt_wr
);
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));  // R6

  AST_RAS_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (ras_n && $past(ras_n)));  // R8

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (ras_n && cas_n));  // R6

  AST_PARALLEL_WHEN_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> ext_allow);  // R7

  AST_COUNTER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 && !cnt_wr) |=> $stable(cnt_q));  // R3

  AST_ACCEPT_STARTS_CBR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refresh_pending) |-> (!cas_n && ras_n));  // R5
endmodule

bind dram_refresh_ctrl refresh_checker #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .ext_allow(ext_allow),
  .refresh_pending(refresh_pending), .seq_busy(seq_busy), .hold_q(hold_q),
  .sel_q(sel_q), .cnt_q(cnt_q), .cnt_wr(cnt_wr)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       standby = 1'b0;
  logic       ras_n, cas_n, ext_allow, refresh_pending, seq_busy;

  always #10 clk = ~clk;  // 50 MHz

  dram_refresh_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .standby(standby), .ras_n(ras_n),
    .cas_n(cas_n), .ext_allow(ext_allow), .refresh_pending(refresh_pending),
    .seq_busy(seq_busy)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit rot_en = 1;
  int cycles = 0;

  // ---------------- reference model ----------------
  int m_en, m_sel, m_hold, m_cmp, m_area, m_cnt, m_pend, m_pre, m_cstep, m_sstep;

  task automatic model_reset();
    m_en = 0; m_sel = 0; m_hold = 0; m_cmp = 255; m_area = 0; m_cnt = 0;
    m_pend = 0; m_pre = 0; m_cstep = 0; m_sstep = 0;
  endtask

  function automatic int div_of(input int code);
    int bits [1:7] = '{1, 3, 5, 7, 9, 11, 12};
    return 1 << bits[code];
  endfunction

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int on, tk, ack, srs, hit, wcnt;
      on   = (m_en != 0 && m_area != 0) ? 1 : 0;
      tk   = (m_sel != 0 && (m_pre % div_of(m_sel)) == div_of(m_sel) - 1) ? 1 : 0;
      wcnt = (wr_en && wr_addr == 2'd3) ? 1 : 0;
      ack  = (m_cstep == 0 && m_sstep == 0 && on && !standby && m_pend) ? 1 : 0;
      srs  = (m_cstep == 0 && m_sstep == 0 && on && standby) ? 1 : 0;
      hit  = (tk && !wcnt && m_cnt == m_cmp && on) ? 1 : 0;
      if (wcnt) m_cnt = int'(wr_data);
      else if (tk) m_cnt = (m_cnt == m_cmp) ? 0 : (m_cnt + 1) % 256;
      if (ack) m_pend = 0; else if (hit) m_pend = 1;
      if (m_cstep != 0) m_cstep = (m_cstep == 5) ? 0 : m_cstep + 1;
      else if (ack) m_cstep = 1;
      case (m_sstep)
        0: if (srs) m_sstep = 1;
        1: m_sstep = 2;
        2: if (!standby) m_sstep = 3;
        3: m_sstep = 4;
        default: m_sstep = 0;
      endcase
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_en = int'(wr_data[0]); m_sel = int'(wr_data[3:1]); m_hold = int'(wr_data[4]); end
          2'd1: m_cmp = int'(wr_data);
          2'd2: m_area = int'(wr_data[2:0]);
          default: ;
        endcase
      end
      m_pre = (m_pre + 1) % 4096;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  int cas_falls = 0, cas_low = 0, ras_low = 0, allow_low = 0;
  bit prev_cas = 1'b1;
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int e_cas, e_ras, e_rd;
      string sreq;
      cycles++;
      sreq  = (m_sstep != 0) ? "R8" : "R6";
      e_cas = (m_cstep >= 1 && m_cstep <= 4) || (m_sstep >= 1 && m_sstep <= 3) ? 0 : 1;
      e_ras = (m_cstep == 2 || m_cstep == 3 || m_sstep == 2) ? 0 : 1;
      chk(sreq, "cas_n", int'(cas_n), e_cas);
      chk(sreq, "ras_n", int'(ras_n), e_ras);
      chk("R6", "seq_busy", int'(seq_busy), (m_cstep != 0 || m_sstep != 0) ? 1 : 0);
      chk("R7", "ext_allow", int'(ext_allow), (m_hold != 0 && m_cstep != 0) ? 0 : 1);
      chk("R5", "refresh_pending", int'(refresh_pending), m_pend);
      case (rd_addr)
        2'd0: e_rd = m_en | (m_sel << 1) | (m_hold << 4);
        2'd1: e_rd = m_cmp;
        2'd2: e_rd = m_area;
        default: e_rd = m_cnt;
      endcase
      chk((rd_addr == 2'd3) ? "R4" : "R2", "rd_data", int'(rd_data), e_rd);
      if (prev_cas && !cas_n) cas_falls++;
      if (!cas_n) cas_low++;
      if (!ras_n) ras_low++;
      if (!ext_allow) allow_low++;
      prev_cas = cas_n;
    end
  end

  always @(negedge clk) if (rot_en) rd_addr <= rd_addr + 2'd1;

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cval(input int en, input int sel, input int hold);
    return 8'(en | (sel << 1) | (hold << 4));
  endfunction

  task automatic clear_counts();
    cas_falls = 0; cas_low = 0; ras_low = 0; allow_low = 0;
  endtask

  task automatic read_reg(input logic [1:0] a, output int v);
    rot_en = 0;
    @(negedge clk);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    int v, v2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    chk("R1", "ras_n", int'(ras_n), 1);
    chk("R1", "cas_n", int'(cas_n), 1);
    chk("R1", "pending", int'(refresh_pending), 0);
    chk("R1", "busy", int'(seq_busy), 0);
    chk("R1", "ext_allow", int'(ext_allow), 1);
    read_reg(2'd1, v); chk("R1", "compare", v, 255);
    read_reg(2'd0, v); chk("R1", "control", v, 0);
    read_reg(2'd3, v); chk("R1", "counter", v, 0);
    rot_en = 1;

    // R2/R4/R6/R7: fast refreshes, no hold
    wr(2'd1, 8'd3); wr(2'd2, 8'd1); wr(2'd0, cval(1, 1, 0));
    clear_counts(); idle(200);
    wr(2'd0, cval(0, 1, 0)); idle(10);
    chk("R6", "refreshes seen", (cas_falls > 0) ? 1 : 0, 1);
    chk("R6", "cas low cycles", cas_low, 4 * cas_falls);
    chk("R6", "ras low cycles", ras_low, 2 * cas_falls);
    chk("R7", "blocked cycles without hold", allow_low, 0);

    // R7: hold bit blocks other accesses for the whole refresh
    wr(2'd0, cval(1, 1, 1));
    clear_counts(); idle(200);
    wr(2'd0, cval(0, 1, 1)); idle(10);
    chk("R7", "blocked cycles with hold", allow_low, 5 * cas_falls);

    // R3: source code 0 freezes the counter
    wr(2'd0, cval(1, 0, 0));
    read_reg(2'd3, v); idle(50); read_reg(2'd3, v2);
    chk("R3", "frozen counter", v2, v);
    rot_en = 1;

    // R4: counter write wins over ticks
    wr(2'd1, 8'h40); wr(2'd0, cval(1, 1, 0)); wr(2'd3, 8'h3E);
    idle(20);
    wr(2'd3, 8'h10);
    read_reg(2'd3, v); chk("R4", "counter after write", (v >= 16 && v <= 17) ? 1 : 0, 1);
    rot_en = 1;

    // R3: divide by 32
    wr(2'd1, 8'd2); wr(2'd0, cval(1, 3, 0)); idle(400);

    // R5: match every tick, requests collide with busy sequencer
    wr(2'd1, 8'd0); wr(2'd0, cval(1, 1, 1)); idle(150);

    // R8: standby during ongoing traffic with a pending request
    standby = 1'b1; idle(15);
    chk("R8", "ras held low", int'(ras_n), 0);
    chk("R8", "cas held low", int'(cas_n), 0);
    chk("R8", "accesses allowed", int'(ext_allow), 1);
    standby = 1'b0; idle(30);

    // R8: standby with timer stopped
    wr(2'd0, cval(1, 0, 0)); idle(10);
    standby = 1'b1; idle(8); standby = 1'b0; idle(10);

    // R9: enable off
    wr(2'd0, cval(0, 1, 0)); wr(2'd1, 8'd1); idle(10);
    clear_counts(); idle(100);
    standby = 1'b1; idle(20); standby = 1'b0; idle(5);
    chk("R9", "strobes with enable off", cas_falls, 0);

    // R9: area field zero
    wr(2'd2, 8'd0); wr(2'd0, cval(1, 1, 0)); idle(10);
    clear_counts(); idle(100);
    standby = 1'b1; idle(20); standby = 1'b0; idle(5);
    chk("R9", "strobes with no DRAM area", cas_falls, 0);
    chk("R9", "no pending with no DRAM area", int'(refresh_pending), 0);

    // R3: slower sources
    wr(2'd2, 8'd6); wr(2'd1, 8'd2);
    wr(2'd0, cval(1, 2, 0)); idle(600);
    wr(2'd0, cval(1, 4, 1)); idle(2000);
    wr(2'd0, cval(1, 5, 0)); wr(2'd1, 8'd1); idle(3000);
    wr(2'd0, cval(1, 6, 0)); idle(5000);
    wr(2'd1, 8'd0); wr(2'd0, cval(1, 7, 1)); idle(9000);
    finish_up();
  end
endmodule